// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register

This block is the write-only set-up port of a transmit modulator. A host sends 24-bit words over three wires: a serial clock, a serial data line and a load strobe. Each bit is taken on a rising edge of the serial clock, and the least significant bit comes first. All three wires are sampled by the block's own system clock, so the serial clock must stay high and stay low for at least two system-clock periods each, and data must be stable while the serial clock is high.

When the strobe rises, the block checks the four lowest word bits against a fixed chip address. If the address matches, it copies the control fields from the word into its registers:

- the two-bit prescaler code,
- the analog/dual mode bit,
- the synthesizer enable,
- the two sleep bits,
- the two clock-divider selects.

The block decodes the sleep bits into a power state and a set of enables for the clock and radio sections.

Top module: `tri_wire_cfg`

## Requirements
- R1: Word bits are shifted in on rising edges of `serClk` with the least significant bit first, so the first bit sent lands at word position 0 after 24 shifts.
- R2: On a rising edge of `serStrobe`, the word is accepted only when positions 0..3 hold 1,0,1,1 (position 0 = 1, position 1 = 0, positions 2 and 3 = 1).
- R3: A strobe while the address field differs from 1,0,1,1 leaves every output unchanged. Shifting bits with no strobe also leaves every output unchanged.
- R4: Field positions are: 4 = N0, 5 = N1, 6 = AD (`dualMode`), 7 = SE (`synthEn`), 8 = SM1, 9 = SM2, 10 = X (`clkADiv3`), 11 = Y (`clkBDiv2`).
- R5: `divRatio` is 6 for N1N0 = 00, 7 for N0 = 1 with N1 = 0, 8 for N0 = 0 with N1 = 1, and 9 for 11.
- R6: Positions 12 to 23 have no effect on any output.
- R7: When SM1 = 0 the block is in sleep: `pwrState` = 0 and `clkAOn`, `loOn`, `clkBOn`, `coreOn` and `synthOn` are all 0, whatever SM2 holds.
- R8: When SM1 = 1 and SM2 = 0 the block is in standby: `pwrState` = 1, `clkAOn` = `loOn` = 1, and `clkBOn` = `coreOn` = `synthOn` = 0.
- R9: When SM1 = 1 and SM2 = 1 the block is fully active: `pwrState` = 2, `clkAOn` = `loOn` = `clkBOn` = `coreOn` = 1, and `synthOn` equals SE.
- R10: After reset every control bit is 0, `divRatio` is 6 and `pwrState` is 0 (sleep).
- R11: A loaded word shows on the outputs by the second rising system-clock edge after `serStrobe` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial shift clock |
| serStrobe | input | 1 | Load strobe; a rising edge loads the word |
| serData | input | 1 | Serial data, least significant bit first |
| divRatio | output | 4 | Decoded prescaler ratio, 6 to 9 |
| dualMode | output | 1 | Registered AD bit |
| synthEn | output | 1 | Registered SE bit |
| sm1Bit | output | 1 | Registered SM1 bit |
| sm2Bit | output | 1 | Registered SM2 bit |
| clkADiv3 | output | 1 | Registered X bit: clock A divides by 3 |
| clkBDiv2 | output | 1 | Registered Y bit: clock B divides by 2 |
| pwrState | output | 2 | 0 = sleep, 1 = standby, 2 = active |
| clkAOn | output | 1 | Clock A path enable |
| loOn | output | 1 | LO buffer enable |
| clkBOn | output | 1 | Clock B path enable |
| coreOn | output | 1 | Transmit core enable |
| synthOn | output | 1 | Synthesizer power enable |

## Verification
Timing of a serial bit:

- A `serClk` rise is seen one system-clock edge after the change.
- The bit is shifted in on the edge after that.

For that reason the bench sets data and clock together on a falling system-clock edge and holds the serial clock high for two periods. A strobe rise writes the registers on the second rising edge after it, and the power enables follow from those registers with no further delay. The bench therefore samples every output on the falling edge after the third rising edge that follows the strobe rise. The checks for ignored input (a bad address, the reserved bits, a word shifted with no strobe) use the same sampling point.

// File: rtl/tri_wire_cfg_pkg.sv
package tri_wire_cfg_pkg;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } ctrlStrobes_t;

  typedef struct packed {
    logic y;
    logic x;
    logic sm2;
    logic sm1;
    logic se;
    logic ad;
    logic n1;
    logic n0;
  } cfgFields_t;

  localparam int FIELD_W = $bits(cfgFields_t);

  typedef enum logic [1:0] {
    PWR_SLEEP   = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_ACTIVE  = 2'd2
  } pwrState_t;

endpackage

// File: rtl/cfg_edge_ctrl.sv
module cfg_edge_ctrl
  import tri_wire_cfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         serStrobe,
  input  logic         serData,
  output logic         dataQ,
  output ctrlStrobes_t strb
);

  logic sclkQ, sclkQQ, stbQ, stbQQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      sclkQQ <= 1'b0;
      stbQ   <= 1'b0;
      stbQQ  <= 1'b0;
      dataQ  <= 1'b0;
    end else begin
      sclkQ  <= serClk;
      sclkQQ <= sclkQ;
      stbQ   <= serStrobe;
      stbQQ  <= stbQ;
      dataQ  <= serData;
    end
  end

  always_comb begin
    strb.shiftEn = sclkQ & ~sclkQQ;
    strb.loadEn  = stbQ & ~stbQQ;
  end

  // R1
  single_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> !strb.shiftEn);

  // R11
  single_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> !strb.loadEn);

endmodule

// File: rtl/cfg_shift_dp.sv
module cfg_shift_dp
  import tri_wire_cfg_pkg::*;
#(
  parameter int              WORD_W    = 24,
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CHIP_ADDR = 4'b1101
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dataQ,
  input  ctrlStrobes_t strb,
  output cfgFields_t   fieldsQ
);

  localparam int FIELD_LO = ADDR_W;
  localparam int FIELD_HI = ADDR_W + FIELD_W - 1;

  logic [WORD_W-1:0] shiftReg;
  logic              addrHit;
  logic              unusedResBits;

  assign addrHit       = (shiftReg[ADDR_W-1:0] == CHIP_ADDR);
  assign unusedResBits = ^shiftReg[WORD_W-1:FIELD_HI+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {dataQ, shiftReg[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldsQ <= '0;
    end else if (strb.loadEn && addrHit) begin
      fieldsQ <= cfgFields_t'(shiftReg[FIELD_HI:FIELD_LO]);
    end
  end

  // R3
  bad_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && !addrHit) |=> $stable(fieldsQ));

  // R3
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> $stable(fieldsQ));

endmodule

// File: rtl/cfg_power_decode.sv
module cfg_power_decode
  import tri_wire_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cfgFields_t fieldsQ,
  output logic [3:0] divRatio,
  output pwrState_t  pwrState,
  output logic       clkAOn,
  output logic       loOn,
  output logic       clkBOn,
  output logic       coreOn,
  output logic       synthOn
);

  always_comb begin
    divRatio = 4'd6 + {3'b000, fieldsQ.n0} + {2'b00, fieldsQ.n1, 1'b0};
    if (!fieldsQ.sm1)     pwrState = PWR_SLEEP;
    else if (fieldsQ.sm2) pwrState = PWR_ACTIVE;
    else                  pwrState = PWR_STANDBY;
    clkAOn  = (pwrState != PWR_SLEEP);
    loOn    = (pwrState != PWR_SLEEP);
    clkBOn  = (pwrState == PWR_ACTIVE);
    coreOn  = (pwrState == PWR_ACTIVE);
    synthOn = (pwrState == PWR_ACTIVE) & fieldsQ.se;
  end

  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divRatio >= 4'd6) && (divRatio <= 4'd9));

  // R9
  active_nests_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkBOn || coreOn || synthOn) |-> (clkAOn && loOn));

  // R7
  sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fieldsQ.sm1 |-> !(clkAOn || loOn || clkBOn || coreOn || synthOn));

endmodule

// File: rtl/tri_wire_cfg.sv
module tri_wire_cfg
  import tri_wire_cfg_pkg::*;
#(
  parameter int                WORD_W    = 24,
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CHIP_ADDR = 4'b1101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serStrobe,
  input  logic       serData,
  output logic [3:0] divRatio,
  output logic       dualMode,
  output logic       synthEn,
  output logic       sm1Bit,
  output logic       sm2Bit,
  output logic       clkADiv3,
  output logic       clkBDiv2,
  output logic [1:0] pwrState,
  output logic       clkAOn,
  output logic       loOn,
  output logic       clkBOn,
  output logic       coreOn,
  output logic       synthOn
);

  ctrlStrobes_t strb;
  cfgFields_t   fieldsQ;
  pwrState_t    stateDec;
  logic         dataQ;

  cfg_edge_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serStrobe(serStrobe),
    .serData(serData), .dataQ(dataQ), .strb(strb)
  );

  cfg_shift_dp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CHIP_ADDR(CHIP_ADDR)) dp_i (
    .clk(clk), .rstN(rstN), .dataQ(dataQ), .strb(strb), .fieldsQ(fieldsQ)
  );

  cfg_power_decode dec_i (
    .clk(clk), .rstN(rstN), .fieldsQ(fieldsQ), .divRatio(divRatio),
    .pwrState(stateDec), .clkAOn(clkAOn), .loOn(loOn), .clkBOn(clkBOn),
    .coreOn(coreOn), .synthOn(synthOn)
  );

  assign pwrState = stateDec;
  assign dualMode = fieldsQ.ad;
  assign synthEn  = fieldsQ.se;
  assign sm1Bit   = fieldsQ.sm1;
  assign sm2Bit   = fieldsQ.sm2;
  assign clkADiv3 = fieldsQ.x;
  assign clkBDiv2 = fieldsQ.y;

endmodule

// File: tb/tri_wire_cfg_tb_top.sv
`timescale 1ns/1ps
module tri_wire_cfg_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serStrobe = 1'b0, serData = 1'b0;
  logic [3:0] divRatio;
  logic dualMode, synthEn, sm1Bit, sm2Bit, clkADiv3, clkBDiv2;
  logic [1:0] pwrState;
  logic clkAOn, loOn, clkBOn, coreOn, synthOn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tri_wire_cfg dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serStrobe(serStrobe),
    .serData(serData), .divRatio(divRatio), .dualMode(dualMode),
    .synthEn(synthEn), .sm1Bit(sm1Bit), .sm2Bit(sm2Bit),
    .clkADiv3(clkADiv3), .clkBDiv2(clkBDiv2), .pwrState(pwrState),
    .clkAOn(clkAOn), .loOn(loOn), .clkBOn(clkBOn), .coreOn(coreOn),
    .synthOn(synthOn)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // address code 1,0,1,1 at positions 0..3 -> 4'b1101
  function automatic logic [23:0] mkWord(input logic [3:0] addr, input logic [7:0] f,
                                         input logic [11:0] junk);
    return {junk, f, addr};
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk);
    serData = b;
    serClk  = 1'b1;
    repeat (2) @(negedge clk);
    serClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [23:0] w);
    for (int i = 0; i < 24; i++) sendBit(w[i]);
  endtask

  task automatic strobe();
    @(negedge clk);
    serStrobe = 1'b1;
    repeat (3) @(negedge clk);
    serStrobe = 1'b0;
  endtask

  // f bit order: 0 N0,1 N1,2 AD,3 SE,4 SM1,5 SM2,6 X,7 Y
  task automatic checkAll(input string req, input logic [7:0] f);
    int expDiv, expState;
    expDiv = 6 + int'(f[0]) + 2 * int'(f[1]);
    expState = !f[4] ? 0 : (f[5] ? 2 : 1);
    check({req, " divRatio"}, divRatio, expDiv);
    check({req, " dualMode"}, dualMode, f[2]);
    check({req, " synthEn"}, synthEn, f[3]);
    check({req, " sm1Bit"}, sm1Bit, f[4]);
    check({req, " sm2Bit"}, sm2Bit, f[5]);
    check({req, " clkADiv3"}, clkADiv3, f[6]);
    check({req, " clkBDiv2"}, clkBDiv2, f[7]);
    check({req, " pwrState"}, pwrState, expState);
    check({req, " clkAOn"}, clkAOn, expState != 0);
    check({req, " loOn"}, loOn, expState != 0);
    check({req, " clkBOn"}, clkBOn, expState == 2);
    check({req, " coreOn"}, coreOn, expState == 2);
    check({req, " synthOn"}, synthOn, (expState == 2) && f[3]);
  endtask

  task automatic loadAndCheck(input string req, input logic [7:0] f, input logic [11:0] junk);
    sendWord(mkWord(4'b1101, f, junk));
    strobe();
    checkAll(req, f);
  endtask

  task automatic testReset();
    checkAll("R10 reset", 8'h00);
  endtask

  task automatic testFields();
    loadAndCheck("R1 R4 pattern a", 8'b0100_0101, 12'h000);
    loadAndCheck("R4 pattern b", 8'b1011_1010, 12'h000);
    loadAndCheck("R4 pattern c", 8'b1111_1111, 12'h000);
  endtask

  task automatic testDiv();
    loadAndCheck("R5 code 00", 8'b0001_0000, 12'h000);
    loadAndCheck("R5 N0 only", 8'b0001_0001, 12'h000);
    loadAndCheck("R5 N1 only", 8'b0001_0010, 12'h000);
    loadAndCheck("R5 code 11", 8'b0001_0011, 12'h000);
  endtask

  task automatic testTiming();
    sendWord(mkWord(4'b1101, 8'b0011_0110, 12'h000));
    @(negedge clk);
    serStrobe = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 due after strobe", divRatio, 8);
    check("R11 state after strobe", pwrState, 2);
    serStrobe = 1'b0;
  endtask

  task automatic testBadAddr();
    logic [7:0] held;
    held = 8'b0101_1001;
    loadAndCheck("R2 good load", held, 12'h000);
    sendWord(mkWord(4'b1100, 8'b1010_0110, 12'h000));
    strobe();
    checkAll("R3 bad addr 1100", held);
    sendWord(mkWord(4'b1011, 8'b1111_1111, 12'h000));
    strobe();
    checkAll("R2 bad addr 1011", held);
    sendWord(mkWord(4'b1101, 8'b0011_0011, 12'h000));
    repeat (4) @(negedge clk);
    checkAll("R3 no strobe", held);
  endtask

  task automatic testReserved();
    loadAndCheck("R6 reserved ones", 8'b0001_0110, 12'hFFF);
    loadAndCheck("R6 reserved mix", 8'b1110_1001, 12'hA5C);
  endtask

  task automatic testPower();
    loadAndCheck("R7 sleep sm2 set", 8'b0010_1000, 12'h000);
    loadAndCheck("R7 sleep", 8'b0000_1000, 12'h000);
    loadAndCheck("R8 standby", 8'b0001_1000, 12'h000);
    loadAndCheck("R9 active se", 8'b0011_1000, 12'h000);
    loadAndCheck("R9 active no se", 8'b0011_0000, 12'h000);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testFields();
    testDiv();
    testTiming();
    testBadAddr();
    testReserved();
    testPower();
    finishRun();
  end

endmodule